// File: doc/BRIEF.md
# Hamming ECC Syndrome Classifier and Bit Fixer

The block judges a page of flash data by its error-correcting codes. For each 256-byte half it takes two 22-bit codes: the code stored in flash and the code computed when the data was read back. Each code carries an 11-bit parity half in bits 10:0 and an 11-bit complement half in bits 21:11. Three code bytes map to a code little-endian, with byte 0 in bits 7:0. The two top bits of byte 2 are dropped before the port.

A start pulse captures both pairs of codes and the page mode. Two clock edges later a one-cycle done strobe marks fresh results. For each half the block reports one of four verdicts: clean, damaged stored code, corrected single-bit error, or uncorrectable error. It also reports a page-level error flag. For a correctable half it gives the byte offset and bit to invert. A small read-modify-write port applies those fixes to any byte passed through it, so a data mover can repair the page on its way out. A 256-byte page uses only the low half. A 512-byte page also checks the high half, whose offsets start at 256.

Top module: `ecc_fixer`

## Requirements
- R1: After reset, done is 0, both verdicts are 0 (clean), page_err is 0, and both fix-valid flags are 0.
- R2: A half is clean (verdict 0, no fix) when its syndrome is zero, or when its stored or its computed code is entirely zero. The syndrome is the computed code XOR the stored code.
- R3: A half whose syndrome has exactly one bit set gets verdict 1 (stored code damaged). No fix is offered for that half.
- R4: A half whose syndrome has exactly 11 bits set, and whose syndrome bits 10:0 XOR syndrome bits 21:11 equal 0x7FF, gets verdict 2 (corrected). Its fix-valid flag is set. The fix byte is syndrome bits 10:3 and the fix bit is syndrome bits 2:0.
- R5: Any other nonzero syndrome with both codes nonzero gets verdict 3 (uncorrectable), with no fix. This includes 11 set bits whose parity and complement halves are not complementary.
- R6: done is high for exactly one cycle, two rising edges after the edge that accepts start. Verdicts, fix data and page_err change only at that edge and hold until the next done.
- R7: With page512 low when start is accepted, the high-half verdict is 0 and its fix-valid flag is 0, whatever the high-half codes are.
- R8: With page512 high, the high half is classified like the low half, and its fix byte offset is 256 plus syndrome bits 10:3. page_err is 1 when either half's verdict is 1 or 3, and 0 otherwise.
- R9: rmw_out equals rmw_in with the fix bit inverted when rmw_addr equals the byte offset of a valid fix, and equals rmw_in otherwise.
- R10: An accepted start clears both fix-valid flags from the next cycle. In the cycle start is accepted, the read-modify-write port still applies the previous fixes.
- R11: A start that arrives while a check is pending (the cycle after an accepted start) is ignored. Holding start high for two cycles yields a single done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; codes and mode are sampled on the accepting edge |
| page512 | input | 1 | 1: two-half 512-byte page, 0: single 256-byte half |
| calc_lo | input | 22 | Computed code for bytes 0..255 |
| stor_lo | input | 22 | Stored code for bytes 0..255 |
| calc_hi | input | 22 | Computed code for bytes 256..511 |
| stor_hi | input | 22 | Stored code for bytes 256..511 |
| done | output | 1 | One-cycle strobe: results updated |
| stat_lo | output | 2 | Low-half verdict: 0 clean, 1 code damaged, 2 corrected, 3 uncorrectable |
| stat_hi | output | 2 | High-half verdict, same encoding |
| page_err | output | 1 | Either half damaged or uncorrectable |
| fix_lo_ok | output | 1 | Low-half fix valid |
| fix_lo_byte | output | 8 | Low-half byte offset to fix |
| fix_lo_bit | output | 3 | Low-half bit to invert |
| fix_hi_ok | output | 1 | High-half fix valid |
| fix_hi_byte | output | 9 | High-half byte offset in the page (256..511) |
| fix_hi_bit | output | 3 | High-half bit to invert |
| rmw_addr | input | 9 | Page byte offset of the byte on the repair port |
| rmw_in | input | 8 | Byte to repair |
| rmw_out | output | 8 | Repaired byte |

## Verification
The read-modify-write repair and the clearing of fixes by a new start can fall in the same cycle. The bench provokes this by presenting a byte at the corrected offset while raising start. In that same cycle it expects the flipped byte. After the accepting edge it expects the byte to pass through unchanged with both fix flags low. In a second overlap, both halves of a 512-byte page carry fixes. Bytes at the high offset and at the same offset in the low half are then judged to make sure only the matching half's bit is flipped.

// File: rtl/ecc_fixer.sv
module ecc_fixer #(
  parameter int HW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          page512,
  input  logic [2*HW-1:0] calc_lo,
  input  logic [2*HW-1:0] stor_lo,
  input  logic [2*HW-1:0] calc_hi,
  input  logic [2*HW-1:0] stor_hi,
  output logic          done,
  output logic [1:0]    stat_lo,
  output logic [1:0]    stat_hi,
  output logic          page_err,
  output logic          fix_lo_ok,
  output logic [HW-4:0] fix_lo_byte,
  output logic [2:0]    fix_lo_bit,
  output logic          fix_hi_ok,
  output logic [HW-3:0] fix_hi_byte,
  output logic [2:0]    fix_hi_bit,
  input  logic [HW-3:0] rmw_addr,
  input  logic [7:0]    rmw_in,
  output logic [7:0]    rmw_out
);
  localparam int CW = 2 * HW;
  localparam logic [1:0] V_CLEAN = 2'd0, V_CODE = 2'd1, V_FIX = 2'd2, V_BAD = 2'd3;

  function automatic logic [1:0] classify(input logic [CW-1:0] syn, input logic zero);
    int n;
    n = 0;
    for (int i = 0; i < CW; i++) n += int'(syn[i]);
    if (zero || syn == '0)                                      return V_CLEAN;
    if (n == 1)                                                 return V_CODE;
    if (n == HW && (syn[HW-1:0] ^ syn[CW-1:HW]) == {HW{1'b1}})  return V_FIX;
    return V_BAD;
  endfunction

  logic          pend, wide_q, z_lo_q, z_hi_q;
  logic [CW-1:0] syn_lo_q, syn_hi_q;
  logic [1:0]    cls_lo, cls_hi;
  logic          take, hit_lo, hit_hi;

  assign take   = start & ~pend;
  assign cls_lo = classify(syn_lo_q, z_lo_q);
  assign cls_hi = wide_q ? classify(syn_hi_q, z_hi_q) : V_CLEAN;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= 1'b0;
      wide_q   <= 1'b0;
      z_lo_q   <= 1'b0;
      z_hi_q   <= 1'b0;
      syn_lo_q <= '0;
      syn_hi_q <= '0;
    end else begin
      pend <= take;
      if (take) begin
        wide_q   <= page512;
        syn_lo_q <= calc_lo ^ stor_lo;
        syn_hi_q <= calc_hi ^ stor_hi;
        z_lo_q   <= (calc_lo == '0) || (stor_lo == '0);
        z_hi_q   <= (calc_hi == '0) || (stor_hi == '0);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done        <= 1'b0;
      stat_lo     <= V_CLEAN;
      stat_hi     <= V_CLEAN;
      page_err    <= 1'b0;
      fix_lo_ok   <= 1'b0;
      fix_hi_ok   <= 1'b0;
      fix_lo_byte <= '0;
      fix_lo_bit  <= '0;
      fix_hi_byte <= '0;
      fix_hi_bit  <= '0;
    end else begin
      done <= pend;
      if (pend) begin
        stat_lo     <= cls_lo;
        stat_hi     <= cls_hi;
        page_err    <= cls_lo[0] | cls_hi[0];
        fix_lo_ok   <= cls_lo == V_FIX;
        fix_hi_ok   <= cls_hi == V_FIX;
        fix_lo_byte <= syn_lo_q[HW-1:3];
        fix_lo_bit  <= syn_lo_q[2:0];
        fix_hi_byte <= {1'b1, syn_hi_q[HW-1:3]};
        fix_hi_bit  <= syn_hi_q[2:0];
      end else if (take) begin
        fix_lo_ok <= 1'b0;
        fix_hi_ok <= 1'b0;
      end
    end

  assign hit_lo  = fix_lo_ok && rmw_addr == {1'b0, fix_lo_byte};
  assign hit_hi  = fix_hi_ok && rmw_addr == fix_hi_byte;
  assign rmw_out = rmw_in ^ (hit_lo ? (8'd1 << fix_lo_bit) : 8'd0)
                          ^ (hit_hi ? (8'd1 << fix_hi_bit) : 8'd0);
endmodule

// File: rtl/ecc_fixer_chk.sv
module ecc_fixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       pend,
  input logic       wide_q,
  input logic       done,
  input logic [1:0] stat_lo,
  input logic [1:0] stat_hi,
  input logic       page_err,
  input logic       fix_lo_ok,
  input logic       fix_hi_ok,
  input logic [7:0] rmw_in,
  input logic [7:0] rmw_out
);
  a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend) |=> ##1 done);
  a_r6_hold_verdicts: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> ($stable(stat_lo) && $stable(stat_hi) && $stable(page_err)));
  a_r7_narrow_page: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wide_q) |=> (stat_hi == 2'd0 && !fix_hi_ok));
  a_r4_fix_matches_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_lo_ok |-> stat_lo == 2'd2) and (fix_hi_ok |-> stat_hi == 2'd2));
  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> page_err == (stat_lo[0] || stat_hi[0]));
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_lo_ok && !fix_hi_ok) |-> rmw_out == rmw_in);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend) |=> (!fix_lo_ok && !fix_hi_ok));
endmodule

bind ecc_fixer ecc_fixer_chk u_chk (.*);

// File: tb/ecc_fixer_bench.sv
module ecc_fixer_bench;
  logic        clk = 0, rst_n = 0, start = 0, page512 = 0;
  logic [21:0] calc_lo = 0, stor_lo = 0, calc_hi = 0, stor_hi = 0;
  logic        done, page_err, fix_lo_ok, fix_hi_ok;
  logic [1:0]  stat_lo, stat_hi;
  logic [7:0]  fix_lo_byte, rmw_in = 0, rmw_out;
  logic [2:0]  fix_lo_bit, fix_hi_bit;
  logic [8:0]  fix_hi_byte, rmw_addr = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ecc_fixer u_ecc_fixer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] stor_of(input logic [10:0] p);
    return {~p, p};
  endfunction

  function automatic logic [21:0] calc_fix(input logic [10:0] p, input logic [10:0] loc);
    return stor_of(p) ^ {~loc, loc};
  endfunction

  task automatic run(input logic [21:0] cl, sl, ch, sh, input logic w);
    @(negedge clk);
    calc_lo = cl; stor_lo = sl; calc_hi = ch; stor_hi = sh; page512 = w; start = 1;
    @(negedge clk);
    start = 0;
    chk("R6 no done after one edge", done, 0);
    @(negedge clk);
    chk("R6 done after two edges", done, 1);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 verdicts", {stat_lo, stat_hi}, 0);
    chk("R1 page_err", page_err, 0);
    chk("R1 fix flags", {fix_lo_ok, fix_hi_ok}, 0);
  endtask

  task automatic t_clean;
    run(stor_of(11'h2C5), stor_of(11'h2C5), 0, 0, 0);
    chk("R2 equal codes", stat_lo, 0);
    chk("R2 no error", page_err, 0);
    run(22'h12345, 22'h0, 0, 0, 0);
    chk("R2 stored zero", stat_lo, 0);
    run(22'h0, 22'h2ABCD, 0, 0, 0);
    chk("R2 computed zero", stat_lo, 0);
    chk("R2 no fix", fix_lo_ok, 0);
  endtask

  task automatic t_code_bad;
    run(stor_of(11'h155) ^ 22'h000400, stor_of(11'h155), 0, 0, 0);
    chk("R3 verdict", stat_lo, 1);
    chk("R3 no fix", fix_lo_ok, 0);
    chk("R8 error flag", page_err, 1);
  endtask

  task automatic t_correct;
    run(calc_fix(11'h3A1, 11'h5A3), stor_of(11'h3A1), 0, 0, 0);
    chk("R4 verdict", stat_lo, 2);
    chk("R4 fix valid", fix_lo_ok, 1);
    chk("R4 byte", fix_lo_byte, 8'hB4);
    chk("R4 bit", fix_lo_bit, 3);
    chk("R8 corrected is not error", page_err, 0);
    @(negedge clk);
    chk("R6 strobe ends", done, 0);
    rmw_addr = 9'h0B4; rmw_in = 8'h00; #1;
    chk("R9 flip", rmw_out, 8'h08);
    rmw_addr = 9'h0B5; rmw_in = 8'h5A; #1;
    chk("R9 other byte", rmw_out, 8'h5A);
    rmw_addr = 9'h1B4; #1;
    chk("R9 high-half alias", rmw_out, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R6 verdict held", {stat_lo, fix_lo_ok}, {2'd2, 1'b1});
  endtask

  task automatic t_uncorr;
    run(stor_of(11'h0F0) ^ 22'h000003, stor_of(11'h0F0), 0, 0, 0);
    chk("R5 two bits", stat_lo, 3);
    chk("R5 error flag", page_err, 1);
    run(stor_of(11'h123) ^ {11'h002, 11'h7FE}, stor_of(11'h123), 0, 0, 0);
    chk("R5 eleven bits not paired", stat_lo, 3);
    chk("R5 no fix", fix_lo_ok, 0);
  endtask

  task automatic t_page;
    run(stor_of(11'h001), stor_of(11'h001), calc_fix(11'h222, 11'h0F1), stor_of(11'h222), 1);
    chk("R8 low clean", stat_lo, 0);
    chk("R8 high corrected", stat_hi, 2);
    chk("R8 high offset", fix_hi_byte, 9'h11E);
    chk("R8 high bit", fix_hi_bit, 1);
    chk("R8 no page error", page_err, 0);
    @(negedge clk);
    rmw_addr = 9'h11E; rmw_in = 8'hFF; #1;
    chk("R9 high flip", rmw_out, 8'hFD);
    rmw_addr = 9'h01E; #1;
    chk("R9 low alias untouched", rmw_out, 8'hFF);
    run(stor_of(11'h001), stor_of(11'h001), stor_of(11'h222) ^ 22'h100000, stor_of(11'h222), 1);
    chk("R8 high code damaged", stat_hi, 1);
    chk("R8 page error from high", page_err, 1);
    run(stor_of(11'h001), stor_of(11'h001), calc_fix(11'h222, 11'h0F1), stor_of(11'h222), 0);
    chk("R7 high ignored", {stat_hi, fix_hi_ok}, 0);
    chk("R7 no page error", page_err, 0);
  endtask

  task automatic t_both_halves;
    run(calc_fix(11'h0AA, 11'h0F1), stor_of(11'h0AA), calc_fix(11'h333, 11'h0F4), stor_of(11'h333), 1);
    chk("R8 both corrected", {stat_lo, stat_hi}, {2'd2, 2'd2});
    @(negedge clk);
    rmw_addr = 9'h01E; rmw_in = 8'h00; #1;
    chk("R9 low half bit only", rmw_out, 8'h02);
    rmw_addr = 9'h11E; #1;
    chk("R9 high half bit only", rmw_out, 8'h10);
  endtask

  task automatic t_start_overlap;
    run(calc_fix(11'h3A1, 11'h5A3), stor_of(11'h3A1), 0, 0, 0);
    @(negedge clk);
    rmw_addr = 9'h0B4; rmw_in = 8'hF0; start = 1; #1;
    chk("R10 fix applies in start cycle", rmw_out, 8'hF8);
    @(negedge clk);
    start = 0;
    chk("R10 fix flags cleared", {fix_lo_ok, fix_hi_ok}, 0);
    chk("R10 passthrough after start", rmw_out, 8'hF0);
    @(negedge clk);
    chk("R6 done for overlapped start", done, 1);
  endtask

  task automatic t_double_start;
    @(negedge clk);
    calc_lo = stor_of(11'h155) ^ 22'h000001; stor_lo = stor_of(11'h155); page512 = 0; start = 1;
    @(negedge clk);
    chk("R11 no done yet", done, 0);
    @(negedge clk);
    start = 0;
    chk("R11 first done", done, 1);
    @(negedge clk);
    chk("R11 no second done", done, 0);
    @(negedge clk);
    chk("R11 still no done", done, 0);
    chk("R11 verdict", stat_lo, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_code_bad();
    t_correct();
    t_uncorr();
    t_page();
    t_both_halves();
    t_start_overlap();
    t_double_start();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule